// File: doc/BRIEF.md
# Cascaded Quadrature Position Counter

This block holds two counter channels of equal width. The lower channel decodes a two-phase incremental encoder and counts up or down on every valid edge of either phase. The upper channel can be set to follow the lower channel's carries. It adds one each time the lower counter wraps upward and subtracts one each time it wraps downward. Together the pair forms one position value twice the channel width.

Each channel has two capture registers, A and B. A rising edge on a capture pin copies the channel's counter into the matching register. A widen-control register lets each capture register also respond to the same-letter pin of the partner channel. With that, one pin edge can latch both halves of the position in the same clock.

Software reaches the block through a flat write port and a combinational read port. Word addresses: 0 is the upper source select (4 bits; code 4'hF selects cascade), 1 is the capture widen control, 2 is the start bits (bit 0 lower, bit 1 upper), 4/5/6 are the lower count, capture A and capture B, and 8/9/10 are the upper count, capture A and capture B. Any other address reads zero.

Top module: `cascade_timer_pair`

## Requirements
- R1: After synchronous reset, both counters, all four capture registers, the source select, the widen control and the start bits read as zero.
- R2: With the lower start bit (address 2, bit 0) at 1, the lower counter uses 4x decoding. With the phase pair written as {A,B}, the sequence 00→10→11→01→00 adds one per step and the reverse sequence subtracts one. Each input passes two synchronizer flops, and the count changes on the third rising clock edge after an input change.
- R3: A transition in which both phases change in the same sample leaves the lower counter unchanged.
- R4: A lower step from all-ones to zero gives a one-cycle pulse on `lo_ovf`. A lower step from zero to all-ones gives a one-cycle pulse on `lo_unf`. At most one of the two is high in any cycle.
- R5: With the source select at 4'hF and both start bits at 1, the upper counter adds one on the same clock edge as each lower overflow and subtracts one on the same clock edge as each lower underflow.
- R6: The upper counter does not change on lower wraps when the source select is not 4'hF or the upper start bit is 0.
- R7: With the lower start bit at 0, phase transitions do not change the lower counter.
- R8: A synchronized rising edge on a channel's own capture pin (`cap_pin` bit 0 lower A, bit 1 lower B, bit 2 upper A, bit 3 upper B) copies that channel's counter into the matching capture register. No other event changes a capture register.
- R9: Widen-control bits (address 1): bit 0 lets upper pin A trigger lower capture A, bit 1 lets upper pin B trigger lower capture B, bit 2 lets lower pin A trigger upper capture A, and bit 3 lets lower pin B trigger upper capture B. With a bit at 0, the partner pin has no effect on that register.
- R10: When one pin edge triggers captures in both channels, both registers latch on the same clock edge, and the two captured halves form the position held at that edge.
- R11: A write to a counter's address loads that counter on the next clock edge. The load overrides a count step in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write word address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 4 | Register read word address |
| rd_data | output | 16 | Read data, combinational from rd_addr |
| phase_a | input | 1 | Encoder phase A, asynchronous |
| phase_b | input | 1 | Encoder phase B, asynchronous |
| cap_pin | input | 4 | Capture pins: lower A, lower B, upper A, upper B |
| lo_ovf | output | 1 | One-cycle pulse on lower upward wrap |
| lo_unf | output | 1 | One-cycle pulse on lower downward wrap |

## Verification
Two things can land on the same clock edge: a lower-counter wrap and the carry or borrow it passes into the upper counter. The stimulus table drives the encoder through zero and through all-ones in both directions and runs one invalid two-phase jump. After each step it reads both counters and records whether an overflow or underflow pulse appeared. Capture coherence is provoked by widening one capture register so that a single pin edge latches both halves, and the bench then compares each half against the counters it loaded beforehand.

// File: rtl/cascade_pkg.sv
package cascade_pkg;

    localparam int CNT_W  = 16;
    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] A_SRC    = 4'd0;
    localparam logic [ADDR_W-1:0] A_WIDEN  = 4'd1;
    localparam logic [ADDR_W-1:0] A_START  = 4'd2;
    localparam logic [ADDR_W-1:0] A_LO_CNT = 4'd4;
    localparam logic [ADDR_W-1:0] A_LO_CPA = 4'd5;
    localparam logic [ADDR_W-1:0] A_LO_CPB = 4'd6;
    localparam logic [ADDR_W-1:0] A_HI_CNT = 4'd8;
    localparam logic [ADDR_W-1:0] A_HI_CPA = 4'd9;
    localparam logic [ADDR_W-1:0] A_HI_CPB = 4'd10;

    localparam logic [3:0] SRC_CASCADE = 4'hF;

    typedef enum logic [1:0] {
        STEP_NONE = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DN   = 2'd2
    } step_t;

    typedef struct packed {
        logic lo_a_wide;
        logic lo_b_wide;
        logic hi_a_wide;
        logic hi_b_wide;
    } widen_t;

    // phases packed {A,B}; A leading B counts up
    function automatic step_t quad_step(input logic [1:0] prev, input logic [1:0] cur);
        case ({prev, cur})
            4'b0010, 4'b1011, 4'b1101, 4'b0100: quad_step = STEP_UP;
            4'b1000, 4'b1110, 4'b0111, 4'b0001: quad_step = STEP_DN;
            default:                            quad_step = STEP_NONE;
        endcase
    endfunction

endpackage

// File: rtl/ctp_sync.sv
module ctp_sync #(
    parameter int N = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] din,
    output logic [N-1:0] dout
);
    logic [N-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            dout   <= '0;
        end else begin
            stage1 <= din;
            dout   <= stage1;
        end
    end
endmodule

// File: rtl/ctp_quad_decoder.sv
module ctp_quad_decoder
    import cascade_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       enable,
    input  logic [1:0] phase_sync,
    output step_t      step
);
    logic [1:0] phase_prev;

    always_ff @(posedge clk) begin
        if (rst) phase_prev <= '0;
        else     phase_prev <= phase_sync;
    end

    always_comb begin
        step = enable ? quad_step(phase_prev, phase_sync) : STEP_NONE;
    end

    // R3: a double-phase jump never produces a step
    assert_invalid_ignored_R3: assert property (@(posedge clk) disable iff (rst)
        ($countones(phase_prev ^ phase_sync) == 2) |-> (step == STEP_NONE));

    // R7: disabled decoder is silent
    assert_disabled_silent_R7: assert property (@(posedge clk) disable iff (rst)
        !enable |-> (step == STEP_NONE));
endmodule

// File: rtl/ctp_channel.sv
module ctp_channel
    import cascade_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  step_t        step,
    input  logic         trig_a,
    input  logic         trig_b,
    output logic [W-1:0] count,
    output logic [W-1:0] cap_a,
    output logic [W-1:0] cap_b,
    output logic         wrap_up,
    output logic         wrap_dn
);
    localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

    always_comb begin
        wrap_up = !load && (step == STEP_UP) && (count == ALL_ONES);
        wrap_dn = !load && (step == STEP_DN) && (count == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (load) begin
            count <= load_val;
        end else begin
            case (step)
                STEP_UP: count <= count + 1'b1;
                STEP_DN: count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_a <= '0;
            cap_b <= '0;
        end else begin
            if (trig_a) cap_a <= count;
            if (trig_b) cap_b <= count;
        end
    end

    // R8: capture registers move only on their trigger
    assert_cap_a_trig_R8: assert property (@(posedge clk) disable iff (rst)
        (cap_a != $past(cap_a)) |-> $past(trig_a));
    assert_cap_b_trig_R8: assert property (@(posedge clk) disable iff (rst)
        (cap_b != $past(cap_b)) |-> $past(trig_b));

    // R11: a load wins over a step
    assert_load_wins_R11: assert property (@(posedge clk) disable iff (rst)
        load |=> (count == $past(load_val)));
endmodule

// File: rtl/cascade_timer_pair.sv
module cascade_timer_pair
    import cascade_pkg::*;
#(
    parameter int CW = cascade_pkg::CNT_W,
    parameter int AW = cascade_pkg::ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [CW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [CW-1:0] rd_data,
    input  logic          phase_a,
    input  logic          phase_b,
    input  logic [3:0]    cap_pin,
    output logic          lo_ovf,
    output logic          lo_unf
);
    localparam logic [CW-1:0] ALL_ONES = {CW{1'b1}};

    logic [3:0]    src_sel;
    widen_t        widen;
    logic          start_lo, start_hi;
    logic          casc_on;

    logic [1:0]    phase_s;
    logic [3:0]    pin_s, pin_prev, pin_rise;

    step_t         lo_step, hi_step;
    logic          lo_load, hi_load;
    logic          lo_wrap_up, lo_wrap_dn;
    logic          hi_wrap_up, hi_wrap_dn;
    logic [CW-1:0] lo_cnt, lo_cpa, lo_cpb;
    logic [CW-1:0] hi_cnt, hi_cpa, hi_cpb;
    logic          lo_trig_a, lo_trig_b, hi_trig_a, hi_trig_b;

    // control registers
    always_ff @(posedge clk) begin
        if (rst) begin
            src_sel  <= '0;
            widen    <= '0;
            start_lo <= 1'b0;
            start_hi <= 1'b0;
        end else if (wr_en) begin
            case (wr_addr)
                A_SRC:   src_sel <= wr_data[3:0];
                A_WIDEN: widen   <= '{lo_a_wide: wr_data[0], lo_b_wide: wr_data[1],
                                      hi_a_wide: wr_data[2], hi_b_wide: wr_data[3]};
                A_START: begin
                    start_lo <= wr_data[0];
                    start_hi <= wr_data[1];
                end
                default: ;
            endcase
        end
    end

    assign casc_on = (src_sel == SRC_CASCADE);
    assign lo_load = wr_en && (wr_addr == A_LO_CNT);
    assign hi_load = wr_en && (wr_addr == A_HI_CNT);

    // input synchronizers
    ctp_sync #(.N(2)) u_phase_sync (
        .clk(clk), .rst(rst), .din({phase_a, phase_b}), .dout(phase_s)
    );
    ctp_sync #(.N(4)) u_pin_sync (
        .clk(clk), .rst(rst), .din(cap_pin), .dout(pin_s)
    );

    always_ff @(posedge clk) begin
        if (rst) pin_prev <= '0;
        else     pin_prev <= pin_s;
    end
    assign pin_rise = pin_s & ~pin_prev;

    assign lo_trig_a = pin_rise[0] | (widen.lo_a_wide & pin_rise[2]);
    assign lo_trig_b = pin_rise[1] | (widen.lo_b_wide & pin_rise[3]);
    assign hi_trig_a = pin_rise[2] | (widen.hi_a_wide & pin_rise[0]);
    assign hi_trig_b = pin_rise[3] | (widen.hi_b_wide & pin_rise[1]);

    ctp_quad_decoder u_quad (
        .clk(clk), .rst(rst), .enable(start_lo), .phase_sync(phase_s), .step(lo_step)
    );

    ctp_channel #(.W(CW)) u_lo (
        .clk(clk), .rst(rst), .load(lo_load), .load_val(wr_data), .step(lo_step),
        .trig_a(lo_trig_a), .trig_b(lo_trig_b),
        .count(lo_cnt), .cap_a(lo_cpa), .cap_b(lo_cpb),
        .wrap_up(lo_wrap_up), .wrap_dn(lo_wrap_dn)
    );

    always_comb begin
        hi_step = STEP_NONE;
        if (casc_on && start_hi) begin
            if (lo_wrap_up)      hi_step = STEP_UP;
            else if (lo_wrap_dn) hi_step = STEP_DN;
        end
    end

    ctp_channel #(.W(CW)) u_hi (
        .clk(clk), .rst(rst), .load(hi_load), .load_val(wr_data), .step(hi_step),
        .trig_a(hi_trig_a), .trig_b(hi_trig_b),
        .count(hi_cnt), .cap_a(hi_cpa), .cap_b(hi_cpb),
        .wrap_up(hi_wrap_up), .wrap_dn(hi_wrap_dn)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_ovf <= 1'b0;
            lo_unf <= 1'b0;
        end else begin
            lo_ovf <= lo_wrap_up;
            lo_unf <= lo_wrap_dn;
        end
    end

    always_comb begin
        case (rd_addr)
            A_SRC:    rd_data = CW'(src_sel);
            A_WIDEN:  rd_data = CW'({widen.hi_b_wide, widen.hi_a_wide,
                                     widen.lo_b_wide, widen.lo_a_wide});
            A_START:  rd_data = CW'({start_hi, start_lo});
            A_LO_CNT: rd_data = lo_cnt;
            A_LO_CPA: rd_data = lo_cpa;
            A_LO_CPB: rd_data = lo_cpb;
            A_HI_CNT: rd_data = hi_cnt;
            A_HI_CPA: rd_data = hi_cpa;
            A_HI_CPB: rd_data = hi_cpb;
            default:  rd_data = '0;
        endcase
    end

    // R4: wrap pulses land on the wrapped value and never together
    assert_ovf_zero_R4: assert property (@(posedge clk) disable iff (rst)
        lo_ovf |-> (lo_cnt == '0));
    assert_unf_ones_R4: assert property (@(posedge clk) disable iff (rst)
        lo_unf |-> (lo_cnt == ALL_ONES));
    assert_flags_excl_R4: assert property (@(posedge clk) disable iff (rst)
        $onehot0({lo_ovf, lo_unf}));

    // R6: the upper counter moves only through cascade or a load
    assert_hi_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (hi_cnt != $past(hi_cnt)) |-> ($past(casc_on && start_hi) || $past(hi_load)));

    // R5: an upper step is always paired with a lower wrap of the same edge
    assert_hi_follows_R5: assert property (@(posedge clk) disable iff (rst)
        (!hi_load && hi_cnt != $past(hi_cnt) && !$past(hi_load)) |-> (lo_ovf || lo_unf));

    // R10: a shared pin edge latches both halves on one edge
    assert_coherent_R10: assert property (@(posedge clk) disable iff (rst)
        (widen.lo_a_wide && pin_rise[2]) |=> (lo_cpa == $past(lo_cnt) && hi_cpa == $past(hi_cnt)));
endmodule

// File: tb/cascade_timer_pair_bench.sv
module cascade_timer_pair_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [3:0]  wr_addr;
    logic [15:0] wr_data;
    logic [3:0]  rd_addr;
    logic [15:0] rd_data;
    logic        phase_a, phase_b;
    logic [3:0]  cap_pin;
    logic        lo_ovf, lo_unf;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    cascade_timer_pair u_cascade_timer_pair (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .phase_a(phase_a), .phase_b(phase_b),
        .cap_pin(cap_pin), .lo_ovf(lo_ovf), .lo_unf(lo_unf)
    );

    // {A,B}, lower, upper, ovf seen, unf seen; start lower=FFFE upper=0 phases 00
    localparam logic [35:0] VEC [0:11] = '{
        {2'b10, 16'hFFFF, 16'h0000, 1'b0, 1'b0},
        {2'b11, 16'h0000, 16'h0001, 1'b1, 1'b0},
        {2'b01, 16'h0001, 16'h0001, 1'b0, 1'b0},
        {2'b00, 16'h0002, 16'h0001, 1'b0, 1'b0},
        {2'b01, 16'h0001, 16'h0001, 1'b0, 1'b0},
        {2'b11, 16'h0000, 16'h0001, 1'b0, 1'b0},
        {2'b10, 16'hFFFF, 16'h0000, 1'b0, 1'b1},
        {2'b00, 16'hFFFE, 16'h0000, 1'b0, 1'b0},
        {2'b11, 16'hFFFE, 16'h0000, 1'b0, 1'b0},
        {2'b01, 16'hFFFF, 16'h0000, 1'b0, 1'b0},
        {2'b00, 16'h0000, 16'h0001, 1'b1, 1'b0},
        {2'b10, 16'h0001, 16'h0001, 1'b0, 1'b0}
    };

    task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] v);
        @(negedge clk);
        rd_addr = a;
        #1 v = rd_data;
    endtask

    task automatic drive_phase(input logic [1:0] ab, output logic so, output logic su);
        so = 1'b0; su = 1'b0;
        @(negedge clk);
        {phase_a, phase_b} = ab;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            so |= lo_ovf;
            su |= lo_unf;
        end
    endtask

    task automatic pulse_pin(input int idx);
        @(negedge clk);
        cap_pin[idx] = 1'b1;
        repeat (6) @(negedge clk);
        cap_pin[idx] = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        logic so, su;
        rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
        phase_a = 1'b0; phase_b = 1'b0; cap_pin = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        for (int a = 0; a < 11; a++) begin
            rd(4'(a), v);
            check(v, 16'h0000, $sformatf("R1 reset addr %0d", a));
        end

        // R7: not started, phases ignored
        drive_phase(2'b10, so, su);
        rd(4'd4, v); check(v, 16'h0000, "R7 stopped lower");
        drive_phase(2'b00, so, su);

        // R11: loads and setup
        wr(4'd4, 16'hFFFE);
        wr(4'd8, 16'h0000);
        wr(4'd0, 16'h000F);
        wr(4'd2, 16'h0003);
        rd(4'd4, v); check(v, 16'hFFFE, "R11 lower load");
        rd(4'd0, v); check(v, 16'h000F, "R11 select readback");

        // R2 R3 R4 R5: table walk
        foreach (VEC[i]) begin
            drive_phase(VEC[i][35:34], so, su);
            rd(4'd4, v); check(v, VEC[i][33:18], $sformatf("R2/R3 lower step %0d", i));
            rd(4'd8, v); check(v, VEC[i][17:2],  $sformatf("R5 upper step %0d", i));
            check({15'd0, so}, {15'd0, VEC[i][1]}, $sformatf("R4 ovf step %0d", i));
            check({15'd0, su}, {15'd0, VEC[i][0]}, $sformatf("R4 unf step %0d", i));
        end

        // R6: select not cascade
        wr(4'd0, 16'h0000);
        wr(4'd4, 16'hFFFF);
        drive_phase(2'b11, so, su);
        rd(4'd4, v); check(v, 16'h0000, "R6 lower wrapped");
        rd(4'd8, v); check(v, 16'h0001, "R6 upper held, select off");
        // R6: cascade selected, upper start off
        wr(4'd0, 16'h000F);
        wr(4'd2, 16'h0001);
        wr(4'd4, 16'hFFFF);
        drive_phase(2'b01, so, su);
        rd(4'd4, v); check(v, 16'h0000, "R6 lower wrapped 2");
        rd(4'd8, v); check(v, 16'h0001, "R6 upper held, start off");
        wr(4'd2, 16'h0000);

        // R8 R9: own pins, widen off
        wr(4'd4, 16'h1234);
        wr(4'd8, 16'h5678);
        pulse_pin(0);
        rd(4'd5, v); check(v, 16'h1234, "R8 lower capA own pin");
        rd(4'd9, v); check(v, 16'h0000, "R9 upper capA untouched, widen off");
        pulse_pin(2);
        rd(4'd9, v); check(v, 16'h5678, "R8 upper capA own pin");
        wr(4'd4, 16'h2222);
        rd(4'd5, v); check(v, 16'h1234, "R9 lower capA untouched, widen off");
        pulse_pin(3);
        rd(4'd6, v); check(v, 16'h0000, "R9 lower capB untouched by upper B");

        // R9 R10: widen lower A, one upper-A edge latches both halves
        wr(4'd1, 16'h0001);
        wr(4'd8, 16'h1111);
        pulse_pin(2);
        rd(4'd5, v); check(v, 16'h2222, "R10 lower capA via upper pin");
        rd(4'd9, v); check(v, 16'h1111, "R10 upper capA same edge");
        // R9: widen upper B, lower-B edge
        wr(4'd1, 16'h0008);
        wr(4'd4, 16'hABCD);
        wr(4'd8, 16'h4321);
        pulse_pin(1);
        rd(4'd6, v); check(v, 16'hABCD, "R9 lower capB own pin");
        rd(4'd11 - 4'd0, v); check(v, 16'h0000, "R1 unmapped address");
        rd(4'd10, v); check(v, 16'h4321, "R9 upper capB via lower pin");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule